// File: doc/BRIEF.md
# Low-Frequency Reader Carrier and Sample Serializer

This block turns one fast master clock into the timing of a low-frequency reader front end. A single divider chain makes a serial bit clock, a coil-drive carrier at one eighth of that rate, and an A/D sample clock that runs at the carrier rate with a fixed phase offset. A one-bit select input chooses between two carrier frequencies: about 125 kHz or about 136 kHz from a 24 MHz master clock.

Once per carrier period the block latches the 8-bit converter sample. It then shifts the sample out MSB first on a framed synchronous serial link to a host, one bit per serial clock period. A whole word therefore fills exactly one carrier period. Data changes on the falling edge of the serial clock, so the host samples it on the rising edge.

The select input is latched only at a carrier-period boundary. This means a change never produces a shortened clock pulse. A debug output mirrors the sample clock, and the high-frequency drive output is held low.

Top module: `lfr_carrier_serializer`

## Requirements
- R1: Each high phase and each low phase of the serial clock lasts BASE_HALF plus the latched select value master cycles. With the default BASE_HALF = 11 this is 12 cycles for select 1 (125 kHz from 24 MHz) and 11 cycles for select 0.
- R2: The select input is latched only at the carrier-period boundary, which is the serial-clock falling edge at which the carrier rises. Out of reset the latched value is 1.
- R3: The carrier is high for the first four serial periods of each carrier period and low for the next four. It changes only on a serial-clock falling edge.
- R4: The sample clock has the carrier's period and a 50% duty cycle. It rises two serial periods after the carrier rises and falls six serial periods after it. It changes only on a serial-clock falling edge.
- R5: The value on the parallel sample input at the boundary edge is sent during the carrier period that follows. Bit 7 is sent first and bit 0 last, one bit per serial period. Serial data changes only on a serial-clock falling edge.
- R6: The frame output is low from reset until the first word begins. From the boundary that starts the first word onward it is high.
- R7: The debug output always equals the sample clock, and the high-frequency drive output is always 0.
- R8: While reset is held, the serial clock, carrier, sample clock, frame and serial data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_slow | input | 1 | Carrier select: 1 picks the lower (125 kHz) carrier, 0 the higher |
| sample_in | input | SAMPLE_W | Parallel converter sample |
| carrier_o | output | 1 | Coil-drive carrier |
| sample_clk_o | output | 1 | A/D sample clock |
| ser_clk_o | output | 1 | Serial bit clock to the host |
| ser_frame_o | output | 1 | Frame, high while words are being shifted |
| ser_data_o | output | 1 | Serial data, MSB first |
| dbg_o | output | 1 | Debug copy of the sample clock |
| hf_drive_o | output | 1 | High-frequency drive, held low |

## Verification
The hardest case to reach from the ports is a select change that lands exactly on the master cycle of a carrier boundary, or one cycle after it. Random select toggles almost never hit that cycle.

To reach it, the bench counts serial-clock falling edges from a rising edge of the sample clock to find the last serial period of a carrier period. It then waits out the known length of the final high phase and flips the select on the falling master-clock edge just before the boundary. It flips the select back right after the boundary.

The phase-length checks then confirm two things: the value present at the boundary edge governs the whole next period, and the quick flip back has no effect until the boundary after that.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

  // Half-period length of the serial clock, in master cycles, for a select value.
  function automatic int unsigned lfr_half_cycles(int unsigned base, logic sel);
    return base + (sel ? 1 : 0);
  endfunction

  // True when slot lies in the window [start, start+len) taken modulo n.
  function automatic bit lfr_in_window(int unsigned slot, int unsigned start,
                                       int unsigned len, int unsigned n);
    return ((slot + n - start) % n) < len;
  endfunction

endpackage

// File: rtl/lfr_bit_clock.sv
module lfr_bit_clock
  import lfr_pkg::*;
#(
  parameter int unsigned BASE_HALF = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic boundary_i,
  output logic sclk_o,
  output logic fall_o
);

  localparam int unsigned CNT_W = $clog2(BASE_HALF + 2);
  localparam logic [CNT_W-1:0] HALF_RST = CNT_W'(lfr_half_cycles(BASE_HALF, 1'b1));

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half_q, half_d;
  logic             sclk_q, sclk_d;
  logic             tick;

  assign tick = (cnt_q == (half_q - CNT_W'(1)));

  always_comb begin
    cnt_d  = cnt_q + CNT_W'(1);
    sclk_d = sclk_q;
    if (tick) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end
  end

  always_comb begin
    half_d = half_q;
    if (boundary_i) begin
      half_d = CNT_W'(lfr_half_cycles(BASE_HALF, sel_i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      half_q <= HALF_RST;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
      half_q <= half_d;
    end
  end

  assign sclk_o = sclk_q;
  assign fall_o = tick & sclk_q;

  // R2
  half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> $stable(half_q));

  // R1
  toggle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_q) |=> $stable(sclk_q));

endmodule

// File: rtl/lfr_phase.sv
module lfr_phase
  import lfr_pkg::*;
#(
  parameter int unsigned SLOTS       = 8,
  parameter int unsigned SAMPLE_RISE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  output logic boundary_o,
  output logic carrier_o,
  output logic sample_clk_o
);

  localparam int unsigned SLOT_W  = $clog2(SLOTS);
  localparam int unsigned HALF_SL = SLOTS / 2;
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);
  localparam bit CAR_RST = lfr_in_window(SLOTS - 1, 0, HALF_SL, SLOTS);
  localparam bit SMP_RST = lfr_in_window(SLOTS - 1, SAMPLE_RISE, HALF_SL, SLOTS);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              car_q, car_d;
  logic              smp_q, smp_d;

  assign boundary_o = fall_i & (slot_q == LAST);

  always_comb begin
    slot_d = slot_q;
    if (boundary_o) begin
      slot_d = '0;
    end else if (fall_i) begin
      slot_d = slot_q + SLOT_W'(1);
    end
    car_d = lfr_in_window(int'(slot_d), 0, HALF_SL, SLOTS);
    smp_d = lfr_in_window(int'(slot_d), SAMPLE_RISE, HALF_SL, SLOTS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= LAST;
      car_q  <= CAR_RST;
      smp_q  <= SMP_RST;
    end else begin
      slot_q <= slot_d;
      car_q  <= car_d;
      smp_q  <= smp_d;
    end
  end

  assign carrier_o    = car_q;
  assign sample_clk_o = smp_q;

  // R3
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_o |=> (slot_q == '0) && car_q);

endmodule

// File: rtl/lfr_shifter.sv
module lfr_shifter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] din_i,
  output logic             dout_o,
  output logic             frame_o
);

  logic [WIDTH-1:0] sh_q, sh_d;
  logic             frame_q, frame_d;

  always_comb begin
    sh_d    = sh_q;
    frame_d = frame_q | load_i;
    if (load_i) begin
      sh_d = din_i;
    end else if (shift_i) begin
      sh_d = {sh_q[WIDTH-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      frame_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      frame_q <= frame_d;
    end
  end

  assign dout_o  = sh_q[WIDTH-1];
  assign frame_o = frame_q;

  // R5
  load_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (dout_o == $past(din_i[WIDTH-1])));

endmodule

// File: rtl/lfr_carrier_serializer.sv
module lfr_carrier_serializer #(
  parameter int unsigned BASE_HALF        = 11,
  parameter int unsigned SAMPLE_W         = 8,
  parameter int unsigned SAMPLE_RISE_SLOT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_slow,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic                carrier_o,
  output logic                sample_clk_o,
  output logic                ser_clk_o,
  output logic                ser_frame_o,
  output logic                ser_data_o,
  output logic                dbg_o,
  output logic                hf_drive_o
);

  localparam int unsigned SLOTS = SAMPLE_W;

  logic rst_meta_q, rst_sync_q;
  logic sclk, fall, boundary, carrier, sample_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  lfr_bit_clock #(.BASE_HALF(BASE_HALF)) u_bit_clock (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .sel_i     (sel_slow),
    .boundary_i(boundary),
    .sclk_o    (sclk),
    .fall_o    (fall)
  );

  lfr_phase #(.SLOTS(SLOTS), .SAMPLE_RISE(SAMPLE_RISE_SLOT)) u_phase (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .fall_i      (fall),
    .boundary_o  (boundary),
    .carrier_o   (carrier),
    .sample_clk_o(sample_clk)
  );

  lfr_shifter #(.WIDTH(SAMPLE_W)) u_shifter (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .load_i (boundary),
    .shift_i(fall & ~boundary),
    .din_i  (sample_in),
    .dout_o (ser_data_o),
    .frame_o(ser_frame_o)
  );

  assign carrier_o    = carrier;
  assign sample_clk_o = sample_clk;
  assign ser_clk_o    = sclk;
  assign dbg_o        = sample_clk;
  assign hf_drive_o   = 1'b0;

  // R3
  carrier_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !$stable(carrier_o) |-> $fell(ser_clk_o));

  // R4
  sample_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !$stable(sample_clk_o) |-> $fell(ser_clk_o));

  // R4
  sample_phase_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(carrier_o) |-> !sample_clk_o);

  // R5
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !$stable(ser_data_o) |-> $fell(ser_clk_o));

  // R6
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(ser_frame_o) |-> $rose(carrier_o));

endmodule

// File: tb/lfr_carrier_serializer_bench.sv
module lfr_carrier_serializer_bench;
  localparam int BASE = 11;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, sel;
  logic [7:0] sample_in;
  logic car, smp, sclk, frame, data, dbg, hf;

  lfr_carrier_serializer u_lfr_carrier_serializer (
    .clk(clk), .rst_n(rst_n), .sel_slow(sel), .sample_in(sample_in),
    .carrier_o(car), .sample_clk_o(smp), .ser_clk_o(sclk),
    .ser_frame_o(frame), .ser_data_o(data), .dbg_o(dbg), .hf_drive_o(hf)
  );

  int total = 0, bad = 0;
  int words = 0;
  bit sel_done = 0, mon_en = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] directed_word(int idx);
    case (idx)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'hA5;
      3: return 8'h01;
      4: return 8'h80;
      default: return 8'h7E;
    endcase
  endfunction

  // reference state of the monitor
  logic p_sclk, p_car, p_smp, p_data;
  int run = 0, exp_half = BASE + 1, falls = 0, nbits = 0;
  bit edge_valid = 0, started = 0, collecting = 0;
  logic [7:0] word_exp, got;

  always @(posedge clk) begin
    #1;
    if (mon_en) begin
      bit s_rise, s_fall, c_rise, c_fall, m_rise, m_fall;
      s_rise = sclk & ~p_sclk;  s_fall = ~sclk & p_sclk;
      c_rise = car & ~p_car;    c_fall = ~car & p_car;
      m_rise = smp & ~p_smp;    m_fall = ~smp & p_smp;
      run++;
      if (sclk != p_sclk) begin
        if (edge_valid) chk(run == exp_half, "R1 phase length", run, exp_half);
        edge_valid = 1;
        run = 0;
      end
      if (s_fall) falls++;
      if (car != p_car) chk(s_fall, "R3 carrier edge on falling sclk", s_fall, 1);
      if (smp != p_smp) chk(s_fall, "R4 sample edge on falling sclk", s_fall, 1);
      if (data != p_data) chk(s_fall, "R5 data edge on falling sclk", s_fall, 1);
      if (c_rise) begin
        if (started) chk(falls == 8, "R3 carrier period", falls, 8);
        falls = 0;
        started = 1;
        exp_half = BASE + int'(sel);   // R2: latched at this boundary
        word_exp = sample_in;
        collecting = 1;
        nbits = 0;
        got = '0;
      end
      if (started && c_fall) chk(falls == 4, "R3 carrier high span", falls, 4);
      if (started && m_rise) chk(falls == 2, "R4 sample rise phase", falls, 2);
      if (started && m_fall) chk(falls == 6, "R4 sample fall phase", falls, 6);
      if (s_rise && collecting) begin
        got = {got[6:0], data};
        nbits++;
        if (nbits == 8) begin
          chk(got == word_exp, "R5 word MSB first", int'(got), int'(word_exp));
          collecting = 0;
          words++;
        end
      end
      chk(frame == started, "R6 frame", frame, started);
      chk(dbg == smp && hf == 1'b0, "R7 dbg/hf", {dbg, hf}, {smp, 1'b0});
      p_sclk = sclk; p_car = car; p_smp = smp; p_data = data;
    end
  end

  // sample driver: new value right after each sample-clock rise
  initial begin
    sample_in = 8'h3C;
    wait (rst_n === 1'b1);
    for (int i = 0; ; i++) begin
      @(posedge smp);
      @(negedge clk);
      sample_in = (i < 6) ? directed_word(i) : 8'($urandom);
    end
  end

  // select driver: random toggles, then changes aimed at the boundary
  initial begin
    sel = 1'b1;
    wait (rst_n === 1'b1);
    for (int i = 0; i < 50; i++) begin
      repeat ($urandom_range(1, 500)) @(negedge clk);
      sel = 1'($urandom);
    end
    for (int k = 0; k < 6; k++) begin
      @(posedge smp);
      repeat (5) @(negedge sclk);
      @(posedge sclk);
      repeat (exp_half) @(negedge clk);
      sel = ~sel;          // lands on the boundary edge (R2)
      @(negedge clk);
      sel = ~sel;          // just after the boundary: held off until next (R2)
    end
    sel_done = 1;
  end

  initial begin
    int unsigned seed_v;
    int cyc;
    seed_v = $urandom(32'd4242);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk(sclk == 0, "R8 ser_clk in reset", sclk, 0);
    chk(car == 0, "R8 carrier in reset", car, 0);
    chk(smp == 0, "R8 sample clock in reset", smp, 0);
    chk(frame == 0, "R8 frame in reset", frame, 0);
    chk(data == 0, "R8 data in reset", data, 0);
    chk(dbg == 0 && hf == 0, "R7 dbg/hf in reset", {dbg, hf}, 0);
    p_sclk = sclk; p_car = car; p_smp = smp; p_data = data;
    rst_n = 1'b1;
    mon_en = 1;
    cyc = 0;
    while (!(sel_done && words >= 150)) begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", words, 150);
        break;
      end
    end
    chk(words >= 150, "R5 words delivered", words, 150);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule